// File: doc/BRIEF.md
# Multi-Bank Write Conflict Buffer

This block sits between P parallel decoder lanes and M single-port memory banks. Every cycle each lane may present one write (bank index, bank-local address, data). A bank can absorb only one write per cycle, so when several lanes aim at the same bank in the same cycle, one of them is forwarded at once and the others are parked in a small circular queue owned by that bank. Queued writes leave one per cycle in later cycles. The lanes are never held back: there is no ready signal.

When a bank's queue is empty, the winning request goes straight to the bank in the same cycle through a combinational bypass. When the queue holds entries, its oldest entry is written first and any new requests for that bank join the tail, so each bank sees its writes in arrival order, with same-cycle requests ordered by port number. A status output tells the surrounding control when every queue has drained and no request is present, which is the moment a half iteration may be closed. A queue that would exceed its capacity drops the surplus and raises a sticky error flag.

Top module: `wconf_buffer`

## Requirements
- R1: A request whose bank queue is empty and which has no lower-numbered competitor for that bank is written to the bank in the same cycle it is presented (mem_we high, address and data taken from that port).
- R2: Each bank is written at most once per cycle; k requests arriving together at a bank with an empty queue are written over k consecutive cycles, starting in the cycle they arrive.
- R3: Among same-cycle requests for one bank the lowest-numbered port is served first and the remaining ones follow in ascending port order.
- R4: While a bank's queue is non-empty, its oldest entry is written in every cycle, and newly arriving requests for that bank are placed behind it, so writes reach the bank in arrival order.
- R5: The block has no back-pressure: every request presented is accepted while the target queue has room.
- R6: A request that finds its bank queue full (QDEPTH entries after the cycle's write-out) is dropped and overflow_err rises in the next cycle and stays high until reset.
- R7: all_empty is high exactly when every bank queue is empty and no wr_valid bit is set.
- R8: While and after synchronous active-low reset, mem_we is zero with no request present, all_empty is high, overflow_err is low and all queues are empty.
- R9: Requests to different banks in the same cycle are served independently and in parallel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | P | Per-port write request |
| wr_bank | input | P*BANK_W | Per-port target bank, port p at bits [p*BANK_W +: BANK_W] |
| wr_addr | input | P*AW | Per-port bank-local address |
| wr_data | input | P*DW | Per-port write data |
| mem_we | output | M | Per-bank write enable |
| mem_addr | output | M*AW | Per-bank write address, bank b at [b*AW +: AW] |
| mem_data | output | M*DW | Per-bank write data, bank b at [b*DW +: DW] |
| all_empty | output | 1 | All queues empty and no request present |
| overflow_err | output | 1 | Sticky queue overflow flag |

## Verification
The bench builds the block with four ports, four banks, 8-bit addresses, 16-bit data and a queue depth of four. With four ports able to hit one bank, a depth of four lets two back-to-back full collisions fill a queue and push past it, so the drop and sticky-flag path is reached in a few cycles, while the same setup also exercises bypass, ordering behind a busy queue and parallel service of distinct banks. Every written word carries a tag of cycle and port, so the bench can tell which request reached which bank in which cycle.

// File: rtl/wconf_pkg.sv
// Shared types for the write conflict buffer.
// Assumes nothing beyond SystemVerilog 2017 packages.
package wconf_pkg;
    // Where a bank's write in a cycle comes from.
    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_HEAD   = 2'd1,
        SRC_BYPASS = 2'd2
    } wconf_src_e;
endpackage

// File: rtl/wconf_detect.sv
// Conflict detector: decodes every port's bank index into a bank-by-port
// hit matrix, hit[b*P+p] set when port p requests bank b this cycle.
// Assumes bank indices below M; an index at or above M selects no bank.
module wconf_detect #(
    parameter int P      = 8,
    parameter int M      = 8,
    parameter int BANK_W = 3
) (
    input  logic [P-1:0]        req_valid,
    input  logic [P*BANK_W-1:0] req_bank,
    output logic [M*P-1:0]      hit
);
    for (genvar b = 0; b < M; b++) begin : g_bank
        for (genvar p = 0; p < P; p++) begin : g_port
            // Port p targets bank b.
            assign hit[b*P+p] = req_valid[p] &&
                                (req_bank[p*BANK_W +: BANK_W] == BANK_W'(b));
        end
    end
endmodule

// File: rtl/wconf_bank_queue.sv
// One bank's conflict handler: priority selection, bypass and a circular
// queue that accepts up to P entries and releases one per cycle.
// Assumes QDEPTH is a power of two and at least 2.
module wconf_bank_queue
    import wconf_pkg::*;
#(
    parameter int P      = 8,
    parameter int AW     = 10,
    parameter int DW     = 16,
    parameter int QDEPTH = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [P-1:0]   hit,
    input  logic [P*AW-1:0] req_addr,
    input  logic [P*DW-1:0] req_data,
    output logic           out_we,
    output logic [AW-1:0]  out_addr,
    output logic [DW-1:0]  out_data,
    output logic           q_empty,
    output logic           ovf_pulse
);
    localparam int PW = $clog2(QDEPTH);
    localparam int CW = $clog2(QDEPTH + 1);

    logic [AW-1:0] q_addr [QDEPTH];
    logic [DW-1:0] q_data [QDEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] count;

    wconf_src_e    src;
    logic          pop, found;
    logic [P-1:0]  bypass_oh, push_mask, accept;
    logic [PW-1:0] slot [P];
    logic [CW:0]   room, n_acc;
    logic [AW-1:0] byp_addr;
    logic [DW-1:0] byp_data;

    assign pop     = (count != '0);
    assign q_empty = !pop;

    // Priority selector: lowest-numbered requesting port wins the bypass.
    always_comb begin
        bypass_oh = '0;
        found     = 1'b0;
        byp_addr  = '0;
        byp_data  = '0;
        for (int p = 0; p < P; p++) begin
            if (hit[p] && !found) begin
                bypass_oh[p] = 1'b1;
                found        = 1'b1;
                byp_addr     = req_addr[p*AW +: AW];
                byp_data     = req_data[p*DW +: DW];
            end
        end
    end

    // Source choice: queue head first, bypass only when the queue is empty.
    always_comb begin
        if (pop)        src = SRC_HEAD;
        else if (found) src = SRC_BYPASS;
        else            src = SRC_NONE;
    end

    // Bank write outputs driven from the chosen source.
    always_comb begin
        out_we   = (src != SRC_NONE);
        out_addr = '0;
        out_data = '0;
        if (src == SRC_HEAD) begin
            out_addr = q_addr[rd_ptr];
            out_data = q_data[rd_ptr];
        end else if (src == SRC_BYPASS) begin
            out_addr = byp_addr;
            out_data = byp_data;
        end
    end

    // Enqueue planning: ascending port order, capacity-limited.
    always_comb begin
        push_mask = (src == SRC_BYPASS) ? (hit & ~bypass_oh) : hit;
        room      = (CW+1)'(QDEPTH) - (CW+1)'(count) + (CW+1)'(pop);
        n_acc     = '0;
        accept    = '0;
        ovf_pulse = 1'b0;
        for (int p = 0; p < P; p++) begin
            slot[p] = wr_ptr + PW'(n_acc);
            if (push_mask[p]) begin
                if (n_acc < room) begin
                    accept[p] = 1'b1;
                    n_acc     = n_acc + 1'b1;
                end else begin
                    ovf_pulse = 1'b1;
                end
            end
        end
    end

    // Queue storage writes for accepted requests (no reset needed).
    always_ff @(posedge clk) begin
        for (int p = 0; p < P; p++) begin
            if (accept[p]) begin
                q_addr[slot[p]] <= req_addr[p*AW +: AW];
                q_data[slot[p]] <= req_data[p*DW +: DW];
            end
        end
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (pop) rd_ptr <= rd_ptr + 1'b1;
            wr_ptr <= wr_ptr + PW'(n_acc);
            count  <= CW'((CW+1)'(count) - (CW+1)'(pop) + n_acc);
        end
    end
endmodule

// File: rtl/wconf_buffer.sv
// Non-stalling multi-bank write conflict buffer (top). Routes up to P
// writes per cycle to M single-port banks, queuing same-bank collisions.
// Assumes bank indices below M and QDEPTH a power of two, at least 2.
module wconf_buffer #(
    parameter int P      = 8,
    parameter int M      = 8,
    parameter int AW     = 10,
    parameter int DW     = 16,
    parameter int QDEPTH = 16,
    parameter int BANK_W = (M > 1) ? $clog2(M) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [P-1:0]        wr_valid,
    input  logic [P*BANK_W-1:0] wr_bank,
    input  logic [P*AW-1:0]     wr_addr,
    input  logic [P*DW-1:0]     wr_data,
    output logic [M-1:0]        mem_we,
    output logic [M*AW-1:0]     mem_addr,
    output logic [M*DW-1:0]     mem_data,
    output logic                all_empty,
    output logic                overflow_err
);
    logic [M*P-1:0] hit;
    logic [M-1:0]   q_empty, ovf_pulse, bank_req;

    wconf_detect #(.P(P), .M(M), .BANK_W(BANK_W)) u_detect (
        .req_valid (wr_valid),
        .req_bank  (wr_bank),
        .hit       (hit)
    );

    for (genvar b = 0; b < M; b++) begin : g_bank
        assign bank_req[b] = |hit[b*P +: P];

        wconf_bank_queue #(.P(P), .AW(AW), .DW(DW), .QDEPTH(QDEPTH)) u_q (
            .clk       (clk),
            .rst_n     (rst_n),
            .hit       (hit[b*P +: P]),
            .req_addr  (wr_addr),
            .req_data  (wr_data),
            .out_we    (mem_we[b]),
            .out_addr  (mem_addr[b*AW +: AW]),
            .out_data  (mem_data[b*DW +: DW]),
            .q_empty   (q_empty[b]),
            .ovf_pulse (ovf_pulse[b])
        );
    end

    // Drain status for half-iteration completion.
    assign all_empty = (&q_empty) && !(|wr_valid);

    // Sticky overflow flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)          overflow_err <= 1'b0;
        else if (|ovf_pulse) overflow_err <= 1'b1;
    end
endmodule

// File: rtl/wconf_buffer_chk.sv
// Assertion checker for wconf_buffer, attached by bind below.
// Assumes the internal per-bank request and queue-empty vectors of the top.
module wconf_buffer_chk #(
    parameter int P = 8,
    parameter int M = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [P-1:0] wr_valid,
    input logic [M-1:0] mem_we,
    input logic [M-1:0] bank_req,
    input logic [M-1:0] q_empty,
    input logic         all_empty,
    input logic         overflow_err
);
    for (genvar b = 0; b < M; b++) begin : g_bank
        // R1: request to an idle bank is written in the same cycle.
        a_r1_bypass_now: assert property (@(posedge clk) disable iff (!rst_n)
            (bank_req[b] && q_empty[b]) |-> mem_we[b]);
        // R4: a non-empty queue drains one entry every cycle.
        a_r4_head_drains: assert property (@(posedge clk) disable iff (!rst_n)
            !q_empty[b] |-> mem_we[b]);
        // R2: a bank with no request and an empty queue is not written.
        a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
            (!bank_req[b] && q_empty[b]) |-> !mem_we[b]);
    end

    // R6: overflow flag is sticky until reset.
    a_r6_sticky_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_err |=> overflow_err);

    // R7: once drained, banks stay quiet until a new request arrives.
    a_r7_drained_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        all_empty |=> (mem_we == '0) || (|wr_valid));
endmodule

bind wconf_buffer wconf_buffer_chk #(.P(P), .M(M)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_valid     (wr_valid),
    .mem_we       (mem_we),
    .bank_req     (bank_req),
    .q_empty      (q_empty),
    .all_empty    (all_empty),
    .overflow_err (overflow_err)
);

// File: tb/wconf_buffer_tb.sv
// Self-checking bench: a vector table walked cycle by cycle, then directed
// reset checks. Each written word carries tag = vector*4 + port.
module wconf_buffer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int P = 4, M = 4, AW = 8, DW = 16, QDEPTH = 4, BW = 2;
    localparam int NV = 18;
    // {valid[3:0], bank[7:0], expected tag per bank [31:0], all_empty, ovf}
    localparam logic [45:0] VEC [NV] = '{
        {4'h0, 8'h00, 32'hFFFFFFFF, 1'b1, 1'b0},  // 0
        {4'hF, 8'hE4, 32'h07060504, 1'b0, 1'b0},  // 1
        {4'hF, 8'h55, 32'hFFFF08FF, 1'b0, 1'b0},  // 2
        {4'h0, 8'h00, 32'hFFFF09FF, 1'b0, 1'b0},  // 3
        {4'h9, 8'h40, 32'hFFFF0A10, 1'b0, 1'b0},  // 4
        {4'h0, 8'h00, 32'hFFFF0BFF, 1'b0, 1'b0},  // 5
        {4'h0, 8'h00, 32'hFFFF13FF, 1'b0, 1'b0},  // 6
        {4'h0, 8'h00, 32'hFFFFFFFF, 1'b1, 1'b0},  // 7
        {4'hF, 8'hAA, 32'hFF20FFFF, 1'b0, 1'b0},  // 8
        {4'hF, 8'hAA, 32'hFF21FFFF, 1'b0, 1'b0},  // 9
        {4'h0, 8'h00, 32'hFF22FFFF, 1'b0, 1'b1},  // 10
        {4'h0, 8'h00, 32'hFF23FFFF, 1'b0, 1'b1},  // 11
        {4'h0, 8'h00, 32'hFF24FFFF, 1'b0, 1'b1},  // 12
        {4'h0, 8'h00, 32'hFF25FFFF, 1'b0, 1'b1},  // 13
        {4'h0, 8'h00, 32'hFFFFFFFF, 1'b1, 1'b1},  // 14
        {4'hF, 8'h3C, 32'h3DFFFF3C, 1'b0, 1'b1},  // 15
        {4'h0, 8'h00, 32'h3EFFFF3F, 1'b0, 1'b1},  // 16
        {4'h0, 8'h00, 32'hFFFFFFFF, 1'b1, 1'b1}   // 17
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [P-1:0]    wr_valid = '0;
    logic [P*BW-1:0] wr_bank = '0;
    logic [P*AW-1:0] wr_addr = '0;
    logic [P*DW-1:0] wr_data = '0;
    logic [M-1:0]    mem_we;
    logic [M*AW-1:0] mem_addr;
    logic [M*DW-1:0] mem_data;
    logic            all_empty, overflow_err;
    int              n_checks = 0, n_fail = 0;
    bit              done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wconf_buffer #(.P(P), .M(M), .AW(AW), .DW(DW), .QDEPTH(QDEPTH)) u_dut (
        .clk, .rst_n, .wr_valid, .wr_bank, .wr_addr, .wr_data,
        .mem_we, .mem_addr, .mem_data, .all_empty, .overflow_err
    );

    function automatic string vec_req(int vi);
        if (vi == 0)       return "R8";
        else if (vi == 1)  return "R1 R9";
        else if (vi <= 3)  return "R3 R5 R2";
        else if (vi <= 6)  return "R4";
        else if (vi == 7)  return "R7";
        else if (vi <= 14) return "R6";
        else               return "R2 R3";
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input int vi, input logic [3:0] v, input logic [7:0] bk);
        wr_valid = v;
        wr_bank  = bk;
        for (int p = 0; p < P; p++) begin
            wr_addr[p*AW +: AW] = 8'(vi*4 + p);
            wr_data[p*DW +: DW] = {8'h5A, 8'(vi*4 + p)};
        end
    endtask

    task automatic check_idle(input string req);
        check(mem_we == '0, req, "mem_we idle", 32'(mem_we), 0);
        check(all_empty == 1'b1, req, "all_empty", 32'(all_empty), 1);
        check(overflow_err == 1'b0, req, "overflow_err", 32'(overflow_err), 0);
    endtask

    // Watchdog: an expired run counts as a failure and still summarizes.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_idle("R8");  // reset state
        rst_n = 1'b1;

        for (int vi = 0; vi < NV; vi++) begin
            logic [45:0] v;
            v = VEC[vi];
            @(negedge clk);
            drive(vi, v[45:42], v[41:34]);
            #2;
            for (int b = 0; b < M; b++) begin
                logic [7:0] tag;
                bit exp_we;
                tag    = v[2 + b*8 +: 8];
                exp_we = (tag != 8'hFF);
                if (exp_we)
                    check(mem_we[b] && mem_addr[b*AW +: AW] == tag &&
                          mem_data[b*DW +: DW] == {8'h5A, tag},
                          vec_req(vi), $sformatf("v%0d bank%0d write", vi, b),
                          {mem_we[b], 7'd0, mem_data[b*DW +: DW], mem_addr[b*AW +: AW]},
                          {1'b1, 7'd0, 8'h5A, tag, tag});
                else
                    check(!mem_we[b], vec_req(vi),
                          $sformatf("v%0d bank%0d idle", vi, b), 32'(mem_we[b]), 0);
            end
            check(all_empty == v[1], "R7", $sformatf("v%0d all_empty", vi),
                  32'(all_empty), 32'(v[1]));
            check(overflow_err == v[0], "R6", $sformatf("v%0d overflow_err", vi),
                  32'(overflow_err), 32'(v[0]));
        end

        // R8: reset with a loaded queue and a set error flag clears all state.
        @(negedge clk);
        drive(20, 4'hF, 8'h00);
        @(negedge clk);
        drive(21, 4'h0, 8'h00);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        check_idle("R8");
        @(negedge clk);
        #2;
        check(mem_we == '0, "R8", "no stale write after reset", 32'(mem_we), 0);

        // R1: single request after reset bypasses to bank 3 at once.
        @(negedge clk);
        drive(22, 4'h4, 8'h30);
        #2;
        check(mem_we == 4'h8 && mem_addr[3*AW +: AW] == 8'd90, "R1",
              "bypass after reset", {mem_we, mem_addr[3*AW +: AW]}, {4'h8, 8'd90});
        @(negedge clk);
        drive(23, 4'h0, 8'h00);
        #2;
        check_idle("R7");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule